// File: doc/BRIEF.md
# Serial Register-Access Bus Master

This block runs register transactions on a four-wire serial bus toward one peripheral whose registers take 5-bit addresses. A user request carries an operation (write or read), an address byte, one write byte, a burst length and a clock divisor. The master frames the transfer with an active-low chip enable. It sends a command byte that selects write or read, and then either shifts out one data byte or shifts in one or more data bytes, all most significant bit first.

A read burst keeps chip enable low across all of its bytes, so a peripheral that auto-increments its address can return a run of consecutive registers, such as seven timekeeping registers, in one frame. Each byte read comes back on the user side with a one-cycle valid strobe. A single done pulse marks the end of the frame. The serial clock idles low, and each of its half-periods lasts a programmable number of system clocks.

Top module: `spi_reg_master`

## Requirements
- R1: Chip enable (spiCsN) is active low. It is high whenever the block is idle, and the serial clock is low whenever chip enable is high. Chip enable falls in a cycle where the serial clock is low, and it rises only after the last clock pulse has ended.
- R2: Every byte on the bus, command and data alike, is transferred most significant bit first.
- R3: On transmitted bits, spiMosi changes only while spiSclk is low and holds steady for the whole high half of the clock.
- R4: On received bits, spiMiso is sampled at the end of the high half of the clock, just before the clock falls.
- R5: A write (reqRead = 0) sends the command byte (reqAddr AND 0x1F) OR 0x20, then exactly one data byte equal to reqData, for exactly 16 clock pulses in the frame. The upper three bits of reqAddr have no effect beyond the masking.
- R6: A read (reqRead = 1) sends the command byte (reqAddr AND 0x1F) OR 0xA0 and then receives reqLen bytes, where a reqLen of 0 counts as 1. Chip enable stays low for the whole burst, and bursts of at least 7 bytes are supported. The frame has 8 + 8 × length clock pulses.
- R7: Each high half-period of spiSclk lasts exactly reqDiv system clocks, where a reqDiv of 0 counts as 1. The divisor is captured when the request is accepted.
- R8: Between the falling edge of the command byte's last clock pulse and the rising edge of the data phase's first pulse, the clock stays low for exactly two half-periods.
- R9: Each received byte appears on rdData together with a single-cycle rdValid pulse, in bus order. rdValid only pulses while chip enable is low.
- R10: busy is high from the cycle after a request is accepted until the frame ends. done pulses for one cycle, with chip enable already high and busy low, exactly once per frame.
- R11: A reqValid while busy is high is ignored. It starts no frame, changes nothing in the current frame and produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken only when not busy |
| reqRead | input | 1 | Operation: 1 = read burst, 0 = single write |
| reqAddr | input | 8 | Register address; only the low 5 bits are used |
| reqData | input | 8 | Byte to write |
| reqLen | input | LEN_W (4) | Number of bytes to read; 0 counts as 1 |
| reqDiv | input | DIV_W (8) | System clocks per serial half-period; 0 counts as 1 |
| busy | output | 1 | A frame is in progress |
| rdData | output | 8 | Last byte received |
| rdValid | output | 1 | One-cycle strobe, rdData holds a new byte |
| done | output | 1 | One-cycle pulse at the end of a frame |
| spiCsN | output | 1 | Chip enable, active low |
| spiSclk | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to the peripheral |
| spiMiso | input | 1 | Serial data from the peripheral |

## Verification
The main function is tried with writes and reads whose address bytes have the top bits both clear and set, which separates correct masking and command-pattern insertion from a plain pass-through. The read bursts used are of length 1, 7, and 0 (counts as one), and the divisors used are 0, 1, 2, 3 and 4. A length or divisor of zero shows whether the zero-as-one rule is applied. The burst of 7 shows whether chip enable stays low and whether bytes arrive in bus order. A peripheral model returns a byte pattern that depends on the command and the byte index, so a bit-order, sampling-edge or byte-order error shows up as a wrong value. A request made in the middle of a frame shows whether busy requests are dropped rather than queued or merged.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam logic [7:0] ADDR_MASK = 8'h1F;
  localparam logic [7:0] CMD_WRITE = 8'h20;
  localparam logic [7:0] CMD_READ  = 8'hA0;
  localparam int         BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TXLO,
    ST_TXHI,
    ST_GAP,
    ST_RXHI,
    ST_RXLO,
    ST_TAIL,
    ST_STOP
  } busState_t;

  typedef struct packed {
    logic loadCmd;
    logic loadWr;
    logic shiftTx;
    logic sampleRx;
    logic byteDone;
  } dpCtl_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick  = run && (cnt == limit - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/spi_reg_ctl.sv
module spi_reg_ctl
  import spi_reg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRead,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [DIV_W-1:0] reqDiv,
  output dpCtl_t           dpCtl,
  output logic             spiCsN,
  output logic             spiSclk,
  output logic             busy,
  output logic             done
);

  localparam int BIT_W = $clog2(BYTE_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_BITS - 1);

  busState_t        state;
  logic [BIT_W-1:0] bitIdx;
  logic [LEN_W-1:0] bytesLeft;
  logic [DIV_W-1:0] divReg;
  logic             inCmd;
  logic             isRd;
  logic             gapLeft;
  logic             tick;
  logic             accept;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .run     (state != ST_IDLE),
    .divisor (divReg),
    .tick    (tick)
  );

  assign accept  = (state == ST_IDLE) && reqValid;
  assign busy    = (state != ST_IDLE);
  assign spiCsN  = (state == ST_IDLE) || (state == ST_STOP);
  assign spiSclk = (state == ST_TXHI) || (state == ST_RXHI);

  always_comb begin
    dpCtl          = '0;
    dpCtl.loadCmd  = accept;
    dpCtl.shiftTx  = tick && (state == ST_TXHI) && (bitIdx != LAST_BIT);
    dpCtl.loadWr   = tick && (state == ST_GAP) && !gapLeft && !isRd;
    dpCtl.sampleRx = tick && (state == ST_RXHI);
    dpCtl.byteDone = tick && (state == ST_RXHI) && (bitIdx == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitIdx    <= '0;
      bytesLeft <= '0;
      divReg    <= '0;
      inCmd     <= 1'b0;
      isRd      <= 1'b0;
      gapLeft   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          isRd      <= reqRead;
          bytesLeft <= (reqLen == '0) ? LEN_W'(1) : reqLen;
          divReg    <= reqDiv;
          inCmd     <= 1'b1;
          bitIdx    <= '0;
          state     <= ST_TXLO;
        end
        ST_TXLO: if (tick) state <= ST_TXHI;
        ST_TXHI: if (tick) begin
          if (bitIdx == LAST_BIT) begin
            bitIdx <= '0;
            if (inCmd) begin
              inCmd   <= 1'b0;
              gapLeft <= isRd;
              state   <= ST_GAP;
            end else begin
              state <= ST_TAIL;
            end
          end else begin
            bitIdx <= bitIdx + BIT_W'(1);
            state  <= ST_TXLO;
          end
        end
        ST_GAP: if (tick) begin
          if (gapLeft)   gapLeft <= 1'b0;
          else if (isRd) state   <= ST_RXHI;
          else           state   <= ST_TXLO;
        end
        ST_RXHI: if (tick) state <= ST_RXLO;
        ST_RXLO: if (tick) begin
          if (bitIdx == LAST_BIT) begin
            bitIdx <= '0;
            if (bytesLeft == LEN_W'(1)) begin
              state <= ST_STOP;
            end else begin
              bytesLeft <= bytesLeft - LEN_W'(1);
              state     <= ST_RXHI;
            end
          end else begin
            bitIdx <= bitIdx + BIT_W'(1);
            state  <= ST_RXHI;
          end
        end
        ST_TAIL: if (tick) state <= ST_STOP;
        ST_STOP: if (tick) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     dpCtl,
  input  logic       reqRead,
  input  logic [7:0] reqAddr,
  input  logic [7:0] reqData,
  input  logic       spiMiso,
  output logic       spiMosi,
  output logic [7:0] rdData,
  output logic       rdValid
);

  logic [7:0] txShift;
  logic [7:0] wrHold;
  logic [6:0] rxShift;
  logic [7:0] cmdByte;

  assign cmdByte = (reqAddr & ADDR_MASK) | (reqRead ? CMD_READ : CMD_WRITE);
  assign spiMosi = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      wrHold  <= '0;
    end else if (dpCtl.loadCmd) begin
      txShift <= cmdByte;
      wrHold  <= reqData;
    end else if (dpCtl.loadWr) begin
      txShift <= wrHold;
    end else if (dpCtl.shiftTx) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= dpCtl.byteDone;
      if (dpCtl.sampleRx) rxShift <= {rxShift[5:0], spiMiso};
      if (dpCtl.byteDone) rdData  <= {rxShift, spiMiso};
    end
  end

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRead,
  input  logic [7:0]       reqAddr,
  input  logic [7:0]       reqData,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [DIV_W-1:0] reqDiv,
  output logic             busy,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             done,
  output logic             spiCsN,
  output logic             spiSclk,
  output logic             spiMosi,
  input  logic             spiMiso
);

  dpCtl_t dpCtl;

  spi_reg_ctl #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqRead  (reqRead),
    .reqLen   (reqLen),
    .reqDiv   (reqDiv),
    .dpCtl    (dpCtl),
    .spiCsN   (spiCsN),
    .spiSclk  (spiSclk),
    .busy     (busy),
    .done     (done)
  );

  spi_reg_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .reqRead (reqRead),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .spiMiso (spiMiso),
    .spiMosi (spiMosi),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk (
  input logic clk,
  input logic rstN,
  input logic spiCsN,
  input logic spiSclk,
  input logic spiMosi,
  input logic rdValid,
  input logic done,
  input logic busy,
  input logic sampleRx
);

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);  // R1

  AST_CS_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> !spiSclk);  // R1

  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiMosi) |-> !spiSclk);  // R3

  AST_SAMPLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sampleRx |-> spiSclk);  // R4

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);  // R9

  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !spiCsN);  // R9

  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (spiCsN && !busy && $past(busy)));  // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R10

endmodule

bind spi_reg_master spi_reg_master_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .spiCsN   (spiCsN),
  .spiSclk  (spiSclk),
  .spiMosi  (spiMosi),
  .rdValid  (rdValid),
  .done     (done),
  .busy     (busy),
  .sampleRx (dpCtl.sampleRx)
);

// File: tb/sim_spi_reg_master.sv
`timescale 1ns/1ps
module sim_spi_reg_master;

  typedef struct packed {
    logic       rd;
    logic [7:0] addr;
    logic [7:0] wdat;
    logic [3:0] len;
    logic [7:0] div;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h05, 8'hA5, 4'd0, 8'd1},
    '{1'b0, 8'hFF, 8'h3C, 4'd0, 8'd3},
    '{1'b1, 8'h12, 8'h00, 4'd1, 8'd2},
    '{1'b1, 8'hE0, 8'h00, 4'd7, 8'd1},
    '{1'b1, 8'h4A, 8'h00, 4'd0, 8'd0},
    '{1'b0, 8'h1F, 8'h00, 4'd0, 8'd4}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqRead = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic [3:0] reqLen = '0;
  logic [7:0] reqDiv = '0;
  logic       busy, rdValid, done, spiCsN, spiSclk, spiMosi;
  logic [7:0] rdData;
  logic       spiMiso = 1'b0;

  int checks = 0;
  int errors = 0;

  // bus monitor and peripheral model state
  int         monRises, monRdCnt, monDone;
  int         hiCnt, hiMin, hiMax, lowCnt, gapLow;
  logic [7:0] monCmd, monData, sShift;
  logic [7:0] monRd [16];
  int         sIdx, sBit;
  logic       prevSclk, prevCs, prevMosi;
  logic       csStartBad, mosiBad, doneCsBad;

  always #2 clk = ~clk;

  spi_reg_master u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqData(reqData), .reqLen(reqLen), .reqDiv(reqDiv),
    .busy(busy), .rdData(rdData), .rdValid(rdValid), .done(done),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  function automatic logic [7:0] respByte(input logic [7:0] cmd, input int j);
    return cmd ^ (8'h5A + 8'(j * 19));
  endfunction

  always @(negedge clk) begin
    if (rdValid && monRdCnt < 16) begin
      monRd[monRdCnt] = rdData;
      monRdCnt++;
    end
    if (done) begin
      monDone++;
      if (!spiCsN) doneCsBad = 1'b1;
    end
    if (prevCs && !spiCsN && spiSclk) csStartBad = 1'b1;
    if (spiSclk && prevSclk && (spiMosi !== prevMosi)) mosiBad = 1'b1;
    if (spiSclk) begin
      if (!prevSclk && !spiCsN) begin
        if (monRises == 8) gapLow = lowCnt;
        lowCnt = 0;
        monRises++;
        if (monRises <= 8) monCmd = {monCmd[6:0], spiMosi};
        else if (monRises <= 16) monData = {monData[6:0], spiMosi};
        if (monRises == 8 && monCmd[7]) begin
          sIdx = 0;
          sBit = 0;
          sShift = respByte(monCmd, 0);
          spiMiso = sShift[7];
        end
      end
      hiCnt++;
    end else begin
      if (prevSclk) begin
        if (hiCnt < hiMin) hiMin = hiCnt;
        if (hiCnt > hiMax) hiMax = hiCnt;
        hiCnt = 0;
        if (monRises > 8 && monCmd[7]) begin
          sBit++;
          if (sBit == 8) begin
            sBit = 0;
            sIdx++;
            sShift = respByte(monCmd, sIdx);
          end else begin
            sShift = {sShift[6:0], 1'b0};
          end
          spiMiso = sShift[7];
        end
      end
      if (!spiCsN) lowCnt++;
    end
    prevSclk = spiSclk;
    prevCs   = spiCsN;
    prevMosi = spiMosi;
  end

  task automatic clearMon();
    monRises = 0; monRdCnt = 0; monDone = 0;
    hiCnt = 0; hiMin = 1000; hiMax = 0; lowCnt = 0; gapLow = -1;
    monCmd = '0; monData = '0; sShift = '0; sIdx = 0; sBit = 0;
    csStartBad = 1'b0; mosiBad = 1'b0; doneCsBad = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(posedge clk); #1;
    reqRead = v.rd; reqAddr = v.addr; reqData = v.wdat;
    reqLen = v.len; reqDiv = v.div; reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    for (int t = 0; t < 8000 && monDone == 0; t++) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic runVec(input vec_t v);
    int divEff, lenEff;
    logic [7:0] expCmd;
    divEff = (v.div == 0) ? 1 : int'(v.div);
    lenEff = (v.len == 0) ? 1 : int'(v.len);
    expCmd = (v.addr & 8'h1F) | (v.rd ? 8'hA0 : 8'h20);
    @(posedge clk);
    clearMon();
    issue(v);
    waitDone();
    if (!v.rd) begin
      chk("R5 R2 write command byte", int'(monCmd), int'(expCmd));
      chk("R5 R2 write data byte", int'(monData), int'(v.wdat));
      chk("R5 write clock pulses", monRises, 16);
      chk("R9 no rdValid on write", monRdCnt, 0);
    end else begin
      chk("R6 R2 read command byte", int'(monCmd), int'(expCmd));
      chk("R6 read clock pulses", monRises, 8 + 8 * lenEff);
      chk("R9 rdValid count", monRdCnt, lenEff);
      for (int j = 0; j < lenEff && j < 16; j++)
        chk("R4 R9 read byte value", int'(monRd[j]), int'(respByte(expCmd, j)));
    end
    chk("R7 min high width", hiMin, divEff);
    chk("R7 max high width", hiMax, divEff);
    chk("R8 command to data gap", gapLow, 2 * divEff);
    chk("R10 one done per frame", monDone, 1);
    chk("R10 done with cs high", int'(doneCsBad), 0);
    chk("R1 cs falls with clock low", int'(csStartBad), 0);
    chk("R3 mosi steady while high", int'(mosiBad), 0);
    chk("R1 cs high after frame", int'(spiCsN), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearMon();
    prevSclk = 1'b0; prevCs = 1'b1; prevMosi = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset cs high", int'(spiCsN), 1);
    chk("R1 reset clock low", int'(spiSclk), 0);
    chk("R10 reset not busy", int'(busy), 0);
    chk("R10 reset no done", int'(done), 0);
    chk("R9 reset no rdValid", int'(rdValid), 0);

    for (int i = 0; i < NVEC; i++) runVec(VEC[i]);

    // R11: a request in the middle of a frame must be dropped
    @(posedge clk);
    clearMon();
    issue('{1'b1, 8'h03, 8'h00, 4'd2, 8'd1});
    repeat (20) @(posedge clk);
    #1;
    reqRead = 1'b0; reqAddr = 8'h10; reqData = 8'hFF; reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    waitDone();
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R11 busy request not run, pulses", monRises, 24);
    chk("R11 command unchanged", int'(monCmd), 8'hA3);
    chk("R11 single done", monDone, 1);
    chk("R11 bytes returned", monRdCnt, 2);
    chk("R11 second byte value", int'(monRd[1]), int'(respByte(8'hA3, 1)));
    chk("R11 idle afterwards", int'(busy), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule